// File: doc/BRIEF.md
# Chained Serial Configuration Receiver

This block takes one configuration bit per clock from a serial stream that several devices share, one behind the other. Each device keeps the first bits it sees for its own configuration store, whose size is a parameter. While the store is still filling, the block drives its onward serial output high, so the devices further down see only idle ones. Once the store is full, every later input bit is passed to the onward output through one register. The next device therefore receives exactly the part of the stream that this device does not consume.

The locally consumed bits are also packed into words, first bit in the most significant position, and handed to a downstream integrity checker with a one-cycle strobe. A sticky full flag tells the surrounding logic that the local portion is complete. An active-low restart input, shared by every device in the chain, drops all loading progress, so the whole chain can be reloaded in lockstep.

Top module: `cfg_chain_loader`

## Requirements
- R1: While `rst` is high, or for any clock edge at which `restart_n` is low, the block ends that edge with `ser_out` = 1, `store_full` = 0 and `word_valid` = 0.
- R2: While `store_full` is 0, `ser_out` is 1.
- R3: Exactly one `ser_in` bit is consumed per clock edge with `restart_n` high. `store_full` becomes 1 at the edge that captures local bit number STORE_BITS, counting from 1 after reset or restart.
- R4: At every edge at which `store_full` is already 1, `ser_in` is registered to `ser_out`, so a forwarded bit appears on `ser_out` one clock after it is sampled.
- R5: Once set, `store_full` stays 1 until `rst` is high or `restart_n` is low.
- R6: After every WORD_W-th consumed bit, `word_valid` is 1 for exactly one cycle. `word_data` then holds the last WORD_W consumed bits, with the earliest in bit WORD_W-1 and the latest in bit 0.
- R7: Bits taken after the store is full are never assembled: `word_valid` stays 0 while forwarding.
- R8: A restart discards a partly filled word and the bit count, so the next word and the next full flag are counted from the first bit after the restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial configuration clock; one bit per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| restart_n | input | 1 | Active-low chain-wide restart; clears all loading progress |
| ser_in | input | 1 | Serial configuration data from the upstream device or source |
| ser_out | output | 1 | Serial data to the next device; high while the local store fills |
| store_full | output | 1 | Sticky flag: the local store has all STORE_BITS bits |
| word_data | output | WORD_W | Assembled word, earliest bit in the MSB |
| word_valid | output | 1 | One-cycle strobe marking a new `word_data` |

## Verification
The bench builds the block with STORE_BITS = 96 and WORD_W = 32. With these values the store holds only three words, so every word boundary, the fill-to-forward change and a long forwarding tail all occur within a few hundred clocks. This small store lets each run be checked at every cycle against an arithmetic model, using all-ones, all-zeros, alternating and irregular bit patterns. Restarts and resets are applied in the middle of a word, in the middle of the store and during forwarding, and each reload is checked again from its first bit.

// File: rtl/cfg_chain_pkg.sv
package cfg_chain_pkg;
  localparam int unsigned DEF_STORE_BITS = 4096;
  localparam int unsigned DEF_WORD_W     = 32;

  function automatic bit sizes_ok(int unsigned store_bits, int unsigned word_w);
    return (word_w >= 2) && (store_bits >= word_w) && ((store_bits % word_w) == 0);
  endfunction
endpackage

// File: rtl/cfg_bit_counter.sv
module cfg_bit_counter #(
  parameter int unsigned STORE_BITS = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic restart_n,
  output logic take,
  output logic full
);
  localparam int unsigned CW = (STORE_BITS > 1) ? $clog2(STORE_BITS) : 1;
  localparam logic [CW-1:0] LAST = CW'(STORE_BITS - 1);

  logic [CW-1:0] cnt;

  assign take = restart_n && !full;

  always_ff @(posedge clk) begin
    if (rst || !restart_n) begin
      cnt  <= '0;
      full <= 1'b0;
    end else if (take) begin
      if (cnt == LAST) begin
        full <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // full only once the last local bit index has been reached
  assert_cnt_at_last_R3: assert property (@(posedge clk) disable iff (rst)
    full |-> (cnt == LAST));

  assert_full_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (full && restart_n) |=> full);
endmodule

// File: rtl/cfg_word_assembler.sv
module cfg_word_assembler #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart_n,
  input  logic              take,
  input  logic              din,
  output logic [WORD_W-1:0] word_data,
  output logic              word_valid
);
  localparam int unsigned BW = $clog2(WORD_W);
  localparam logic [BW-1:0] BLAST = BW'(WORD_W - 1);

  logic [BW-1:0]     bidx;
  logic [WORD_W-1:0] shreg;
  logic [WORD_W-1:0] next_word;

  assign next_word = {shreg[WORD_W-2:0], din};

  always_ff @(posedge clk) begin
    if (rst || !restart_n) begin
      bidx       <= '0;
      shreg      <= '0;
      word_valid <= 1'b0;
      if (rst) word_data <= '0;
    end else begin
      word_valid <= 1'b0;
      if (take) begin
        shreg <= next_word;
        if (bidx == BLAST) begin
          bidx       <= '0;
          word_data  <= next_word;
          word_valid <= 1'b1;
        end else begin
          bidx <= bidx + 1'b1;
        end
      end
    end
  end

  assert_valid_single_R6: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> !word_valid);

  assert_valid_from_take_R7: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> $past(take));
endmodule

// File: rtl/cfg_passthru.sv
module cfg_passthru (
  input  logic clk,
  input  logic rst,
  input  logic restart_n,
  input  logic full,
  input  logic din,
  output logic dout
);
  always_ff @(posedge clk) begin
    if (rst || !restart_n) begin
      dout <= 1'b1;
    end else if (full) begin
      dout <= din;
    end else begin
      dout <= 1'b1;
    end
  end

  assert_forward_R4: assert property (@(posedge clk) disable iff (rst)
    (full && restart_n) |=> (dout == $past(din)));
endmodule

// File: rtl/cfg_chain_loader.sv
module cfg_chain_loader
  import cfg_chain_pkg::*;
#(
  parameter int unsigned STORE_BITS = DEF_STORE_BITS,
  parameter int unsigned WORD_W     = DEF_WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart_n,
  input  logic              ser_in,
  output logic              ser_out,
  output logic              store_full,
  output logic [WORD_W-1:0] word_data,
  output logic              word_valid
);
  generate
    if (!sizes_ok(STORE_BITS, WORD_W)) begin : g_bad_size
      $error("STORE_BITS must be a nonzero multiple of WORD_W");
    end
  endgenerate

  logic take;

  cfg_bit_counter #(.STORE_BITS(STORE_BITS)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .restart_n (restart_n),
    .take      (take),
    .full      (store_full)
  );

  cfg_word_assembler #(.WORD_W(WORD_W)) u_asm (
    .clk        (clk),
    .rst        (rst),
    .restart_n  (restart_n),
    .take       (take),
    .din        (ser_in),
    .word_data  (word_data),
    .word_valid (word_valid)
  );

  cfg_passthru u_fwd (
    .clk       (clk),
    .rst       (rst),
    .restart_n (restart_n),
    .full      (store_full),
    .din       (ser_in),
    .dout      (ser_out)
  );

  assert_hold_high_R2: assert property (@(posedge clk) disable iff (rst)
    !store_full |-> ser_out);

  // the last local bit also completes the last word
  assert_last_word_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(store_full) |-> word_valid);
endmodule

// File: tb/cfg_chain_loader_test.sv
module cfg_chain_loader_test;
  localparam int SB = 96;
  localparam int W  = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         restart_n = 1'b1;
  logic         ser_in = 1'b0;
  logic         ser_out;
  logic         store_full;
  logic [W-1:0] word_data;
  logic         word_valid;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  cfg_chain_loader #(.STORE_BITS(SB), .WORD_W(W)) uut (
    .clk        (clk),
    .rst        (rst),
    .restart_n  (restart_n),
    .ser_in     (ser_in),
    .ser_out    (ser_out),
    .store_full (store_full),
    .word_data  (word_data),
    .word_valid (word_valid)
  );

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic pat(int p, int k);
    case (p)
      0: return 1'b1;
      1: return 1'b0;
      2: return k[0];
      default: return (((k * 13 + 5) % 7) > 3) ? 1'b1 : 1'b0;
    endcase
  endfunction

  task automatic step(logic b, logic pn, logic r);
    @(negedge clk);
    ser_in    = b;
    restart_n = pn;
    rst       = r;
    @(posedge clk);
    #1;
  endtask

  task automatic idle_checks(string req);
    check({req, " ser_out"}, W'(ser_out), W'(1));
    check({req, " store_full"}, W'(store_full), W'(0));
    check({req, " word_valid"}, W'(word_valid), W'(0));
  endtask

  task automatic run_stream(int p, int n);
    logic [W-1:0] ew = '0;
    for (int k = 0; k < n; k++) begin
      logic b = pat(p, k);
      logic local_bit = (k < SB);
      logic exp_valid = local_bit && ((k % W) == W - 1);
      step(b, 1'b1, 1'b0);
      if (local_bit) ew = {ew[W-2:0], b};
      if (local_bit)
        check("R2 held high while filling", W'(ser_out), W'(1));
      else
        check("R4 forwarded bit", W'(ser_out), W'(b));
      check("R3/R5 store_full", W'(store_full), W'(k >= SB - 1));
      if (local_bit)
        check("R6/R8 word_valid", W'(word_valid), W'(exp_valid));
      else
        check("R7 no word while forwarding", W'(word_valid), W'(0));
      if (exp_valid) check("R6 word_data MSB-first", word_data, ew);
    end
  endtask

  task automatic restart_pulse();
    for (int i = 0; i < 2; i++) begin
      step(1'b0, 1'b0, 1'b0);
      idle_checks("R1/R8 restart");
    end
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin
      step(1'b1, 1'b1, 1'b1);
      idle_checks("R1 reset");
    end
    run_stream(3, SB + 40);
    restart_pulse();
    run_stream(0, 50);
    restart_pulse();
    run_stream(2, SB + 33);
    restart_pulse();
    run_stream(1, SB + 10);
    restart_pulse();
    run_stream(3, 40);
    step(1'b0, 1'b1, 1'b1);
    idle_checks("R1 reset mid-load");
    run_stream(2, 17);
    restart_pulse();
    run_stream(0, SB + 20);
    restart_pulse();
    run_stream(3, SB + 64);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule